// File: doc/BRIEF.md
# Snoop Line-State Responder

Each core in a coherent cluster carries this responder on its slave-side snoop port. The central coherence manager sends it a command together with a line address. The responder looks up that address in a private duplicate of the level-one data tags. It applies the MESI change that the command calls for and answers with the state the line held before the change. When the peer must give up dirty data, or must pass its copy on to the requester, the reply is followed by the full line as a burst of data beats.

The core keeps its own copy of the tags. The core-side logic is reduced here to a fill port, which writes a tag, a state and a line into both tag copies and the data array, and a read port on the core's tag copy. The snoop lookup reads only its own copy, so it never contends with the core for a read. Any state change that a snoop makes is written to both copies on the same edge. If the core writes the same index on that edge, the core write is dropped. The cache is direct-mapped, so the low address bits select the line and the remaining bits form the tag.

A four-state machine runs each intervention:

- **IDLE** accepts a command when `iv_valid` is high. Transition: IDLE to LOOKUP.
- **LOOKUP** reads the snoop tag copy and the data line, and writes the new state. Transition: LOOKUP to REPLY.
- **REPLY** drives the reply for one cycle. Transition: REPLY to BEATS when data follows, otherwise REPLY to IDLE.
- **BEATS** streams the line. Transition: BEATS to IDLE after the final beat.

Top module: `snoop_line_responder`

## Requirements
- R1: After reset, every line in both tag copies is Invalid (state code 0), `iv_ready` is high, and `rsp_valid` and `dat_valid` are low.
- R2: A command accepted on a clock edge where `iv_valid` and `iv_ready` are both high gets a reply. `rsp_valid` is high for exactly one cycle, and that cycle starts on the second edge after acceptance.
  - Address layout: `iv_addr` = {tag, index}.
  - Hit rule: a hit is a tag match on a line that is not Invalid.
  - State codes: I=0, S=1, E=2, M=3. On a miss, `rsp_state` reports I. On a hit, it reports the prior state.
  - Reply codes: miss=0, clean hit=1, dirty hit=2. A hit is dirty exactly when the prior state is M.
  - Command codes: 0 own-read, 1 shared-read, 2 upgrade, 3 copy-back, 4 purge, 5 I/O inject, 6 I/O remove, 7 probe.
- R3: An own-read (0) that hits moves the line to I. It returns the line data only when the prior state was M.
- R4: A shared-read (1) that hits moves the line to S. It returns the line data for any hit state.
- R5: An upgrade (2) that hits moves the line to I and returns no data.
- R6: A copy-back (3) that hits an M line moves it to S and returns the data. A copy-back that hits an S or E line leaves the state unchanged and returns no data.
- R7: Purge (4), I/O inject (5) and I/O remove (6) move a hitting line to I. They return no data, even when the line was M.
- R8: A miss under any command, and a probe (7) under any condition, leaves both tag copies unchanged and returns no data.
- R9: When `rsp_has_data` is high, BEATS data beats follow on consecutive cycles, starting the cycle after the reply. Beat 0 is the lowest BEAT_W bits of the line. `dat_last` marks only the final beat. The data is the line content at lookup time. No beats follow a reply without data.
- R10: A state change made by an intervention is visible on the core-side tag read port (`cpu_rd_state`) in the reply cycle.
- R11: A core write to the same index on the lookup edge is dropped entirely (tag, state and line) when the intervention changes that line's state. A core write on that edge proceeds normally when it targets a different index, or when the intervention leaves the state unchanged.
- R12: `iv_ready` is low from the acceptance edge until the reply, and any data beats, have finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Core fill write enable |
| cpu_wr_idx | input | IDX_W | Core fill index |
| cpu_wr_tag | input | TAG_W | Core fill tag |
| cpu_wr_state | input | 2 | Core fill line state |
| cpu_wr_line | input | BEATS*BEAT_W | Core fill line data |
| cpu_rd_idx | input | IDX_W | Index read from the core tag copy |
| cpu_rd_tag | output | TAG_W | Tag in the core tag copy |
| cpu_rd_state | output | 2 | State in the core tag copy |
| iv_valid | input | 1 | Intervention command valid |
| iv_ready | output | 1 | Responder idle, command may be accepted |
| iv_cmd | input | 3 | Intervention command code |
| iv_addr | input | TAG_W+IDX_W | Line address {tag, index} |
| rsp_valid | output | 1 | Reply valid, one cycle |
| rsp_code | output | 2 | Miss, clean hit or dirty hit |
| rsp_state | output | 2 | Line state before the intervention |
| rsp_has_data | output | 1 | Data beats follow this reply |
| dat_valid | output | 1 | Data beat valid |
| dat_beat | output | BEAT_W | Data beat |
| dat_last | output | 1 | Final data beat |

## Verification
A wrong state in the snoop tag copy stays hidden until the next intervention to that index. It then shows as a wrong `rsp_state` or `rsp_code` two edges after acceptance, so the bench probes lines after every change. If the two tag copies drift apart, the core read port disagrees with what the next probe reports. The bench therefore compares the core read port in each reply cycle against the same line state. A sequencer that hangs or skips a state shows up as a missing reply, missing or extra beats, or `iv_ready` staying low, within BEATS+3 cycles of acceptance.

// File: rtl/snp_pkg.sv
package snp_pkg;

    // MESI line state encoding
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_SHR = 2'd1,
        LS_EXC = 2'd2,
        LS_MOD = 2'd3
    } line_st_t;

    // Intervention command encoding
    typedef enum logic [2:0] {
        IC_OWN_RD    = 3'd0,
        IC_SHR_RD    = 3'd1,
        IC_UPGRADE   = 3'd2,
        IC_COPY_BACK = 3'd3,
        IC_PURGE     = 3'd4,
        IC_IO_INJECT = 3'd5,
        IC_IO_REMOVE = 3'd6,
        IC_PROBE     = 3'd7
    } iv_cmd_t;

    // Reply classification
    typedef enum logic [1:0] {
        RC_MISS  = 2'd0,
        RC_CLEAN = 2'd1,
        RC_DIRTY = 2'd2
    } rsp_code_t;

endpackage

// File: rtl/snp_tag_copy.sv
// One copy of the direct-mapped tag and state array.
// Two write ports (core fill and snoop state update), one async read port.
module snp_tag_copy
    import snp_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_we,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [1:0]       fill_st,
    input  logic             snp_we,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [1:0]       snp_st,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [1:0]       rd_st
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [1:0]       st_q  [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                tag_q[i] <= '0;
                st_q[i]  <= LS_INV;
            end
        end else begin
            if (fill_we) begin
                tag_q[fill_idx] <= fill_tag;
                st_q[fill_idx]  <= fill_st;
            end
            if (snp_we) begin
                st_q[snp_idx] <= snp_st;
            end
        end
    end

    assign rd_tag = tag_q[rd_idx];
    assign rd_st  = st_q[rd_idx];

endmodule

// File: rtl/snp_line_store.sv
// Line data array: core fill write, async whole-line read for the snoop side.
module snp_line_store #(
    parameter int IDX_W  = 4,
    parameter int LINE_W = 128
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line
);
    localparam int LINES = 1 << IDX_W;

    logic [LINE_W-1:0] mem_q [LINES];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wr_idx] <= wr_line;
        end
    end

    assign rd_line = mem_q[rd_idx];

endmodule

// File: rtl/snp_xition.sv
// Combinational MESI transition chosen by intervention command.
module snp_xition
    import snp_pkg::*;
(
    input  logic [2:0] cmd_i,
    input  logic       hit_i,
    input  logic [1:0] prior_i,
    output logic [1:0] next_o,
    output logic       change_o,
    output logic       data_o,
    output logic [1:0] code_o
);
    line_st_t prior;
    line_st_t nxt;
    iv_cmd_t  cmd;

    always_comb begin
        prior  = line_st_t'(prior_i);
        cmd    = iv_cmd_t'(cmd_i);
        nxt    = prior;
        data_o = 1'b0;
        if (hit_i) begin
            unique case (cmd)
                IC_OWN_RD: begin
                    nxt    = LS_INV;
                    data_o = (prior == LS_MOD);
                end
                IC_SHR_RD: begin
                    nxt    = LS_SHR;
                    data_o = 1'b1;
                end
                IC_UPGRADE: begin
                    nxt = LS_INV;
                end
                IC_COPY_BACK: begin
                    if (prior == LS_MOD) begin
                        nxt    = LS_SHR;
                        data_o = 1'b1;
                    end
                end
                IC_PURGE, IC_IO_INJECT, IC_IO_REMOVE: begin
                    nxt = LS_INV;
                end
                IC_PROBE: begin
                    nxt = prior;
                end
            endcase
        end
        next_o   = nxt;
        change_o = hit_i && (nxt != prior);
        if (!hit_i) begin
            code_o = RC_MISS;
        end else if (prior == LS_MOD) begin
            code_o = RC_DIRTY;
        end else begin
            code_o = RC_CLEAN;
        end
    end

endmodule

// File: rtl/snoop_line_responder.sv
module snoop_line_responder
    import snp_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int TAG_W  = 8,
    parameter int BEAT_W = 32,
    parameter int BEATS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_wr_en,
    input  logic [IDX_W-1:0]          cpu_wr_idx,
    input  logic [TAG_W-1:0]          cpu_wr_tag,
    input  logic [1:0]                cpu_wr_state,
    input  logic [BEATS*BEAT_W-1:0]   cpu_wr_line,
    input  logic [IDX_W-1:0]          cpu_rd_idx,
    output logic [TAG_W-1:0]          cpu_rd_tag,
    output logic [1:0]                cpu_rd_state,
    input  logic                      iv_valid,
    output logic                      iv_ready,
    input  logic [2:0]                iv_cmd,
    input  logic [TAG_W+IDX_W-1:0]    iv_addr,
    output logic                      rsp_valid,
    output logic [1:0]                rsp_code,
    output logic [1:0]                rsp_state,
    output logic                      rsp_has_data,
    output logic                      dat_valid,
    output logic [BEAT_W-1:0]         dat_beat,
    output logic                      dat_last
);
    localparam int ADDR_W   = TAG_W + IDX_W;
    localparam int LINE_W   = BEATS * BEAT_W;
    localparam int BCW      = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int N_COPIES = 2;
    localparam int CPU_COPY = 0;
    localparam int SNP_COPY = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_REPLY,
        ST_BEATS
    } fsm_t;

    fsm_t st_q;
    fsm_t st_d;

    logic [2:0]        cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        code_q;
    logic [1:0]        prior_q;
    logic              dflag_q;
    logic [LINE_W-1:0] line_q;
    logic [BCW-1:0]    beat_q;

    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic [1:0]        lk_next;
    logic [1:0]        lk_code;
    logic              lk_change;
    logic              lk_data;
    logic              snp_we;
    logic              fill_ok;
    logic [LINE_W-1:0] rd_line;
    logic              last_beat;

    logic [TAG_W-1:0]  copy_tag    [N_COPIES];
    logic [1:0]        copy_st     [N_COPIES];
    logic [IDX_W-1:0]  copy_rd_idx [N_COPIES];

    // ---------------------------------------------------------------
    // Lookup against the snoop-side tag copy
    // ---------------------------------------------------------------
    assign lk_idx = addr_q[IDX_W-1:0];
    assign lk_tag = addr_q[ADDR_W-1:IDX_W];
    assign lk_hit = (copy_st[SNP_COPY] != LS_INV) && (copy_tag[SNP_COPY] == lk_tag);

    snp_xition u_xition (
        .cmd_i    (cmd_q),
        .hit_i    (lk_hit),
        .prior_i  (copy_st[SNP_COPY]),
        .next_o   (lk_next),
        .change_o (lk_change),
        .data_o   (lk_data),
        .code_o   (lk_code)
    );

    // Snoop state write happens on the lookup edge; it wins an index clash.
    assign snp_we  = (st_q == ST_LOOKUP) && lk_change;
    assign fill_ok = cpu_wr_en && !(snp_we && (cpu_wr_idx == lk_idx));

    // ---------------------------------------------------------------
    // Duplicated tag arrays: one read port each, identical writes
    // ---------------------------------------------------------------
    assign copy_rd_idx[CPU_COPY] = cpu_rd_idx;
    assign copy_rd_idx[SNP_COPY] = lk_idx;

    for (genvar c = 0; c < N_COPIES; c++) begin : g_copy
        snp_tag_copy #(
            .IDX_W (IDX_W),
            .TAG_W (TAG_W)
        ) u_tags (
            .clk      (clk),
            .rst_n    (rst_n),
            .fill_we  (fill_ok),
            .fill_idx (cpu_wr_idx),
            .fill_tag (cpu_wr_tag),
            .fill_st  (cpu_wr_state),
            .snp_we   (snp_we),
            .snp_idx  (lk_idx),
            .snp_st   (lk_next),
            .rd_idx   (copy_rd_idx[c]),
            .rd_tag   (copy_tag[c]),
            .rd_st    (copy_st[c])
        );
    end

    assign cpu_rd_tag   = copy_tag[CPU_COPY];
    assign cpu_rd_state = copy_st[CPU_COPY];

    snp_line_store #(
        .IDX_W  (IDX_W),
        .LINE_W (LINE_W)
    ) u_data (
        .clk     (clk),
        .we      (fill_ok),
        .wr_idx  (cpu_wr_idx),
        .wr_line (cpu_wr_line),
        .rd_idx  (lk_idx),
        .rd_line (rd_line)
    );

    // ---------------------------------------------------------------
    // Sequencer
    // ---------------------------------------------------------------
    assign last_beat = (beat_q == BCW'(BEATS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (iv_valid) st_d = ST_LOOKUP;
            ST_LOOKUP: st_d = ST_REPLY;
            ST_REPLY:  st_d = dflag_q ? ST_BEATS : ST_IDLE;
            ST_BEATS:  if (last_beat) st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            code_q  <= RC_MISS;
            prior_q <= LS_INV;
            dflag_q <= 1'b0;
            line_q  <= '0;
            beat_q  <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (iv_valid) begin
                        cmd_q  <= iv_cmd;
                        addr_q <= iv_addr;
                    end
                end
                ST_LOOKUP: begin
                    code_q  <= lk_code;
                    prior_q <= lk_hit ? copy_st[SNP_COPY] : LS_INV;
                    dflag_q <= lk_data;
                    line_q  <= rd_line;
                end
                ST_REPLY: begin
                    beat_q <= '0;
                end
                ST_BEATS: begin
                    beat_q <= beat_q + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        iv_ready     = 1'b0;
        rsp_valid    = 1'b0;
        dat_valid    = 1'b0;
        dat_last     = 1'b0;
        rsp_code     = code_q;
        rsp_state    = prior_q;
        rsp_has_data = dflag_q;
        dat_beat     = line_q[beat_q*BEAT_W +: BEAT_W];
        unique case (st_q)
            ST_IDLE:   iv_ready = 1'b1;
            ST_LOOKUP: iv_ready = 1'b0;
            ST_REPLY:  rsp_valid = 1'b1;
            ST_BEATS: begin
                dat_valid = 1'b1;
                dat_last  = last_beat;
            end
        endcase
    end

endmodule

// File: rtl/snp_resp_chk.sv
module snp_resp_chk
    import snp_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       iv_valid,
    input logic       iv_ready,
    input logic       rsp_valid,
    input logic [1:0] rsp_code,
    input logic [1:0] rsp_state,
    input logic       rsp_has_data,
    input logic       dat_valid,
    input logic       dat_last
);

    // R2
    reply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R2
    reply_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iv_valid && iv_ready) |=> ##1 rsp_valid);

    // R2
    dirty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_code == RC_DIRTY) == (rsp_state == LS_MOD)));

    // R2
    miss_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_MISS) |-> (rsp_state == LS_INV));

    // R8
    miss_nodata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RC_MISS) |-> !rsp_has_data);

    // R9
    data_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_has_data) |=> dat_valid);

    // R9
    no_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_has_data) |=> !dat_valid);

    // R9
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_valid && dat_last) |=> !dat_valid);

    // R9
    last_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_last |-> dat_valid);

    // R12
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || dat_valid) |-> !iv_ready);

    // R12
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iv_valid && iv_ready) |=> !iv_ready);

endmodule

bind snoop_line_responder snp_resp_chk u_resp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .iv_valid     (iv_valid),
    .iv_ready     (iv_ready),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code),
    .rsp_state    (rsp_state),
    .rsp_has_data (rsp_has_data),
    .dat_valid    (dat_valid),
    .dat_last     (dat_last)
);

// File: tb/test_snoop_line_responder.sv
module test_snoop_line_responder;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W  = 4;
    localparam int TAG_W  = 8;
    localparam int BEAT_W = 32;
    localparam int BEATS  = 4;
    localparam int LINE_W = BEATS * BEAT_W;
    localparam int LINES  = 1 << IDX_W;

    logic                    clk;
    logic                    rst_n;
    logic                    cpu_wr_en;
    logic [IDX_W-1:0]        cpu_wr_idx;
    logic [TAG_W-1:0]        cpu_wr_tag;
    logic [1:0]              cpu_wr_state;
    logic [LINE_W-1:0]       cpu_wr_line;
    logic [IDX_W-1:0]        cpu_rd_idx;
    logic [TAG_W-1:0]        cpu_rd_tag;
    logic [1:0]              cpu_rd_state;
    logic                    iv_valid;
    logic                    iv_ready;
    logic [2:0]              iv_cmd;
    logic [TAG_W+IDX_W-1:0]  iv_addr;
    logic                    rsp_valid;
    logic [1:0]              rsp_code;
    logic [1:0]              rsp_state;
    logic                    rsp_has_data;
    logic                    dat_valid;
    logic [BEAT_W-1:0]       dat_beat;
    logic                    dat_last;

    snoop_line_responder #(
        .IDX_W(IDX_W), .TAG_W(TAG_W), .BEAT_W(BEAT_W), .BEATS(BEATS)
    ) i_snoop_line_responder (
        .clk(clk), .rst_n(rst_n),
        .cpu_wr_en(cpu_wr_en), .cpu_wr_idx(cpu_wr_idx), .cpu_wr_tag(cpu_wr_tag),
        .cpu_wr_state(cpu_wr_state), .cpu_wr_line(cpu_wr_line),
        .cpu_rd_idx(cpu_rd_idx), .cpu_rd_tag(cpu_rd_tag), .cpu_rd_state(cpu_rd_state),
        .iv_valid(iv_valid), .iv_ready(iv_ready), .iv_cmd(iv_cmd), .iv_addr(iv_addr),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_state(rsp_state),
        .rsp_has_data(rsp_has_data), .dat_valid(dat_valid), .dat_beat(dat_beat),
        .dat_last(dat_last)
    );

    // Encodings taken from the requirements
    localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_E = 2'd2, S_M = 2'd3;
    localparam logic [2:0] C_OWN = 3'd0, C_SHR = 3'd1, C_UPG = 3'd2, C_CPB = 3'd3,
                           C_PRG = 3'd4, C_INJ = 3'd5, C_REM = 3'd6, C_PRB = 3'd7;

    typedef struct packed {
        logic [1:0]        code;
        logic [1:0]        prior;
        logic              has;
        logic [LINE_W-1:0] line;
    } exp_t;

    exp_t  exp_q [$];
    string req_q [$];

    logic [TAG_W-1:0]  ref_tag  [LINES];
    logic [1:0]        ref_st   [LINES];
    logic [LINE_W-1:0] ref_line [LINES];

    int n_chk  = 0;
    int n_fail = 0;

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [LINE_W-1:0] act, input logic [LINE_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic logic [LINE_W-1:0] mk_line(input logic [BEAT_W-1:0] seed);
        logic [LINE_W-1:0] l;
        for (int b = 0; b < BEATS; b++) l[b*BEAT_W +: BEAT_W] = seed + BEAT_W'(b);
        return l;
    endfunction

    // Expected transition from the requirement text
    function automatic void predict(input logic [2:0] cmd, input logic hit, input logic [1:0] ps,
                                    output logic [1:0] ns, output logic has);
        ns  = ps;
        has = 1'b0;
        if (hit) begin
            case (cmd)
                C_OWN: begin ns = S_I; has = (ps == S_M); end
                C_SHR: begin ns = S_S; has = 1'b1; end
                C_UPG: ns = S_I;
                C_CPB: if (ps == S_M) begin ns = S_S; has = 1'b1; end
                C_PRG, C_INJ, C_REM: ns = S_I;
                default: ns = ps;
            endcase
        end
    endfunction

    // ------------------------------------------------------------
    // Monitor: pops expected replies and compares reply and beats
    // ------------------------------------------------------------
    exp_t              mon_e;
    string             mon_req;
    logic [LINE_W-1:0] mon_line;
    bit                mon_beats_due = 1'b0;
    int                mon_beat = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mon_beats_due) begin
                check("R9", "beat present", dat_valid, 1'b1);
                if (dat_valid) begin
                    check("R9", {mon_req, " beat data"}, dat_beat,
                          mon_line[mon_beat*BEAT_W +: BEAT_W]);
                    check("R9", "last flag", dat_last, (mon_beat == BEATS-1));
                    mon_beat++;
                    if (mon_beat == BEATS) mon_beats_due = 1'b0;
                end else begin
                    mon_beats_due = 1'b0;
                end
            end else if (dat_valid) begin
                check("R9", "unexpected beat", 1'b1, 1'b0);
            end
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2", "unexpected reply", 1'b1, 1'b0);
                end else begin
                    mon_e   = exp_q.pop_front();
                    mon_req = req_q.pop_front();
                    check(mon_req, "reply code", rsp_code, mon_e.code);
                    check(mon_req, "reply state", rsp_state, mon_e.prior);
                    check(mon_req, "has data", rsp_has_data, mon_e.has);
                    mon_line      = mon_e.line;
                    mon_beat      = 0;
                    mon_beats_due = mon_e.has;
                end
            end
        end
    end

    // ------------------------------------------------------------
    // Driver tasks
    // ------------------------------------------------------------
    task automatic cpu_fill(input logic [IDX_W-1:0] ix, input logic [TAG_W-1:0] tg,
                            input logic [1:0] st, input logic [LINE_W-1:0] ln);
        @(negedge clk);
        cpu_wr_en    = 1'b1;
        cpu_wr_idx   = ix;
        cpu_wr_tag   = tg;
        cpu_wr_state = st;
        cpu_wr_line  = ln;
        @(negedge clk);
        cpu_wr_en = 1'b0;
        ref_tag[ix]  = tg;
        ref_st[ix]   = st;
        ref_line[ix] = ln;
    endtask

    task automatic check_copy(input logic [IDX_W-1:0] ix, input string req);
        cpu_rd_idx = ix;
        #1;
        check(req, "core copy state", cpu_rd_state, ref_st[ix]);
        check(req, "core copy tag", cpu_rd_tag, ref_tag[ix]);
    endtask

    task automatic send_iv(input logic [2:0] cmd, input logic [TAG_W-1:0] tg,
                           input logic [IDX_W-1:0] ix, input string req,
                           input bit cw = 1'b0,
                           input logic [IDX_W-1:0] cw_ix = '0,
                           input logic [TAG_W-1:0] cw_tg = '0,
                           input logic [1:0] cw_st = '0,
                           input logic [LINE_W-1:0] cw_ln = '0);
        exp_t       e;
        logic       hit;
        logic [1:0] ns;
        logic       has;
        logic       blocked;
        @(negedge clk);
        while (!iv_ready) @(negedge clk);
        hit = (ref_st[ix] != S_I) && (ref_tag[ix] == tg);
        predict(cmd, hit, ref_st[ix], ns, has);
        e.code  = !hit ? 2'd0 : ((ref_st[ix] == S_M) ? 2'd2 : 2'd1);
        e.prior = hit ? ref_st[ix] : S_I;
        e.has   = has;
        e.line  = ref_line[ix];
        exp_q.push_back(e);
        req_q.push_back(req);
        iv_valid = 1'b1;
        iv_cmd   = cmd;
        iv_addr  = {tg, ix};
        @(negedge clk);                  // lookup cycle
        iv_valid = 1'b0;
        check("R12", "ready during lookup", iv_ready, 1'b0);
        if (cw) begin
            cpu_wr_en    = 1'b1;
            cpu_wr_idx   = cw_ix;
            cpu_wr_tag   = cw_tg;
            cpu_wr_state = cw_st;
            cpu_wr_line  = cw_ln;
        end
        @(negedge clk);                  // reply cycle
        cpu_wr_en = 1'b0;
        blocked = cw && hit && (ns != ref_st[ix]) && (cw_ix == ix);
        if (hit) ref_st[ix] = ns;
        if (cw && !blocked) begin
            ref_tag[cw_ix]  = cw_tg;
            ref_st[cw_ix]   = cw_st;
            ref_line[cw_ix] = cw_ln;
        end
        check("R2", "reply on second edge", rsp_valid, 1'b1);
        check("R12", "ready during reply", iv_ready, 1'b0);
        check_copy(ix, "R10");
        while (!iv_ready) @(negedge clk);
    endtask

    // ------------------------------------------------------------
    // Stimulus
    // ------------------------------------------------------------
    initial begin
        rst_n        = 1'b0;
        cpu_wr_en    = 1'b0;
        cpu_wr_idx   = '0;
        cpu_wr_tag   = '0;
        cpu_wr_state = '0;
        cpu_wr_line  = '0;
        cpu_rd_idx   = '0;
        iv_valid     = 1'b0;
        iv_cmd       = '0;
        iv_addr      = '0;
        for (int i = 0; i < LINES; i++) begin
            ref_tag[i]  = '0;
            ref_st[i]   = S_I;
            ref_line[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "ready after reset", iv_ready, 1'b1);
        check("R1", "reply idle", rsp_valid, 1'b0);
        check("R1", "beats idle", dat_valid, 1'b0);
        check_copy(4'd3, "R1");
        check_copy(4'd15, "R1");
        send_iv(C_PRB, 8'h00, 4'd3, "R1");

        // Fill lines
        cpu_fill(4'd1, 8'hA1, S_M, mk_line(32'h1000_0000));
        cpu_fill(4'd2, 8'hB2, S_E, mk_line(32'h2000_0000));
        cpu_fill(4'd3, 8'hC3, S_S, mk_line(32'h3000_0000));
        cpu_fill(4'd4, 8'hD4, S_M, mk_line(32'h4000_0000));
        cpu_fill(4'd5, 8'hE5, S_E, mk_line(32'h5000_0000));
        cpu_fill(4'd6, 8'hF6, S_S, mk_line(32'h6000_0000));
        cpu_fill(4'd7, 8'h17, S_M, mk_line(32'h7000_0000));
        cpu_fill(4'd8, 8'h28, S_E, mk_line(32'h8000_0000));
        cpu_fill(4'd9, 8'h39, S_S, mk_line(32'h9000_0000));
        cpu_fill(4'd10, 8'h4A, S_M, mk_line(32'hA000_0000));
        check_copy(4'd1, "R10");

        // R3 own-read
        send_iv(C_OWN, 8'hA1, 4'd1, "R3");
        send_iv(C_OWN, 8'hB2, 4'd2, "R3");
        // R8 miss by tag mismatch
        send_iv(C_OWN, 8'h99, 4'd3, "R8");
        send_iv(C_PRB, 8'hC3, 4'd3, "R8");

        // R4 shared-read on M, E, S
        send_iv(C_SHR, 8'hD4, 4'd4, "R4");
        send_iv(C_SHR, 8'hE5, 4'd5, "R4");
        send_iv(C_SHR, 8'hC3, 4'd3, "R4");

        // R5 upgrade
        send_iv(C_UPG, 8'hF6, 4'd6, "R5");

        // R6 copy-back on M then E
        send_iv(C_CPB, 8'h4A, 4'd10, "R6");
        send_iv(C_CPB, 8'h4A, 4'd10, "R6");
        send_iv(C_CPB, 8'h28, 4'd8, "R6");

        // R7 purge on M, inject on E, remove on S
        cpu_fill(4'd11, 8'h5B, S_M, mk_line(32'hB000_0000));
        send_iv(C_PRG, 8'h5B, 4'd11, "R7");
        send_iv(C_INJ, 8'h28, 4'd8, "R7");
        send_iv(C_REM, 8'h39, 4'd9, "R7");
        send_iv(C_PRB, 8'h5B, 4'd11, "R7");

        // R8 probe on a dirty line leaves it dirty
        send_iv(C_PRB, 8'h17, 4'd7, "R8");
        send_iv(C_PRB, 8'h17, 4'd7, "R8");

        // R11 snoop change wins over core fill at same index
        send_iv(C_OWN, 8'h17, 4'd7, "R11", 1'b1, 4'd7, 8'h77, S_E, mk_line(32'hDEAD_0000));
        check_copy(4'd7, "R11");
        send_iv(C_PRB, 8'h77, 4'd7, "R11");
        send_iv(C_PRB, 8'h17, 4'd7, "R11");

        // R11 no-change snoop lets same-index fill through
        send_iv(C_SHR, 8'hC3, 4'd3, "R11", 1'b1, 4'd3, 8'h33, S_M, mk_line(32'hC0DE_0000));
        send_iv(C_PRB, 8'h33, 4'd3, "R11");
        send_iv(C_CPB, 8'h33, 4'd3, "R11");

        // R11 different-index fill alongside a changing snoop
        cpu_fill(4'd12, 8'h6C, S_M, mk_line(32'hCC00_0000));
        send_iv(C_SHR, 8'h6C, 4'd12, "R11", 1'b1, 4'd13, 8'h7D, S_M, mk_line(32'hDD00_0000));
        check_copy(4'd13, "R11");
        send_iv(C_OWN, 8'h7D, 4'd13, "R11");

        // R9 full-width line at the top index
        cpu_fill(4'd15, 8'hFF, S_M, {32'hFFFF_0003, 32'h0000_0002, 32'h8000_0001, 32'h0000_0000});
        send_iv(C_SHR, 8'hFF, 4'd15, "R9");

        repeat (BEATS + 4) @(negedge clk);
        check("R2", "outstanding replies", exp_q.size(), 0);
        check("R12", "ready at end", iv_ready, 1'b1);
        summary();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual still running expected finished");
        summary();
    end

endmodule